// File: doc/BRIEF.md
# Shift and Bit-Manipulation Unit

This execution unit performs the 32-bit integer bit operations of a processor datapath: the four bitwise logic functions, left and right shifts (logical and arithmetic), right rotation, counting of leading ones or zeros, byte exchange inside each halfword and sign extension of the low byte. It sits beside the adder and multiplier in an execute stage and takes one operation per clock.

Every cycle the unit samples an operation code, a primary operand, a secondary operand used only by the logic functions and a 5-bit shift amount. It computes the result combinationally and captures it in an output register. The result is therefore visible one clock after the operation is presented, and a new operation may be issued every cycle.

Top module: `bitu_top`

## Requirements
- R1: While the synchronous active-high reset is asserted at a clock edge, the result register is loaded with zero.
- R2: The result of an operation presented before a rising edge appears on the result output right after that edge, and a different operation can be issued on every cycle.
- R3: Operation codes 0, 1, 2 and 3 return the bitwise AND, OR, XOR and NOR of the two operands.
- R4: Code 4 shifts the primary operand left and code 5 shifts it right by the shift amount, with zeros entering the vacated positions.
- R5: Code 6 shifts the primary operand right by the shift amount, with copies of operand bit 31 entering the vacated positions.
- R6: Code 7 rotates the primary operand right by the shift amount; bits leaving position 0 enter at position 31.
- R7: With a shift amount of zero, codes 4, 5, 6 and 7 return the primary operand unchanged.
- R8: Code 8 returns the number of consecutive one bits starting at bit 31 and moving down; code 9 returns the number of consecutive zero bits from bit 31 down.
- R9: Code 8 with an all-ones operand and code 9 with a zero operand both return 32.
- R10: Code 10 exchanges the two bytes inside each 16-bit halfword of the primary operand.
- R11: Code 11 returns bits 7:0 of the primary operand with bit 7 copied into bits 31:8.
- R12: Codes 12 to 15 return zero.
- R13: The secondary operand has no effect on codes 4 to 11, and the shift amount has no effect on codes 0 to 3 and 8 to 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | Primary operand |
| opb_i | input | 32 | Secondary operand for logic functions |
| shamt_i | input | 5 | Shift or rotate amount |
| res_o | output | 32 | Registered result |

## Verification
Back-to-back issue is the case where two functions share a cycle: while the register presents the result of one operation, the combinational path is already computing the next, possibly of a different kind (a rotate followed by a leading-zero count, then a byte swap). The bench issues such streams without idle cycles, with the secondary operand and shift amount changed between operations that should ignore them, and judges each registered value against an independent bit-by-bit model of the operation issued one cycle earlier.

// File: rtl/bitu_pkg.sv
package bitu_pkg;

    localparam int DATA_W  = 32;
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int CNT_W   = SHAMT_W + 1;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_NOR  = 4'd3,
        OP_SHL  = 4'd4,
        OP_SHRL = 4'd5,
        OP_SHRA = 4'd6,
        OP_ROR  = 4'd7,
        OP_LONE = 4'd8,
        OP_LZER = 4'd9,
        OP_BSWH = 4'd10,
        OP_SXB  = 4'd11
    } op_e;

    typedef struct packed {
        logic left;
        logic arith;
        logic rotate;
    } shift_ctl_t;

    typedef enum logic [1:0] {
        SRC_LOGIC,
        SRC_SHIFT,
        SRC_COUNT,
        SRC_BYTES
    } src_e;

    typedef struct packed {
        src_e       src;
        logic       valid_code;
        logic [1:0] logic_fn;
        shift_ctl_t sh;
        logic       count_ones;
        logic       byte_sext;
    } dec_t;

    function automatic dec_t decode_op(input logic [OP_W-1:0] code);
        dec_t d;
        d = '0;
        d.src = SRC_LOGIC;
        d.valid_code = 1'b1;
        d.logic_fn = code[1:0];
        case (code)
            OP_AND, OP_OR, OP_XOR, OP_NOR: d.src = SRC_LOGIC;
            OP_SHL:  begin d.src = SRC_SHIFT; d.sh.left = 1'b1; end
            OP_SHRL: d.src = SRC_SHIFT;
            OP_SHRA: begin d.src = SRC_SHIFT; d.sh.arith = 1'b1; end
            OP_ROR:  begin d.src = SRC_SHIFT; d.sh.rotate = 1'b1; end
            OP_LONE: begin d.src = SRC_COUNT; d.count_ones = 1'b1; end
            OP_LZER: d.src = SRC_COUNT;
            OP_BSWH: d.src = SRC_BYTES;
            OP_SXB:  begin d.src = SRC_BYTES; d.byte_sext = 1'b1; end
            default: d.valid_code = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bitu_logic.sv
module bitu_logic #(
    parameter int W = bitu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/bitu_shift.sv
module bitu_shift #(
    parameter int W  = bitu_pkg::DATA_W,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]         a,
    input  logic [SW-1:0]        amt,
    input  bitu_pkg::shift_ctl_t ctl,
    output logic [W-1:0]         y
);
    logic [W-1:0] a_rev;
    logic [W-1:0] stage [0:SW];
    logic [W-1:0] out_rev;
    logic         msb;

    assign msb = a[W-1];

    generate
        for (genvar k = 0; k < W; k++) begin : g_rev
            assign a_rev[k]   = a[W-1-k];
            assign out_rev[k] = stage[SW][W-1-k];
        end
    endgenerate

    assign stage[0] = ctl.left ? a_rev : a;

    generate
        for (genvar i = 0; i < SW; i++) begin : g_stage
            localparam int D = 1 << i;
            logic [D-1:0] fill;
            always_comb begin
                if (ctl.rotate)
                    fill = stage[i][D-1:0];
                else if (ctl.arith)
                    fill = {D{msb}};
                else
                    fill = '0;
            end
            assign stage[i+1] = amt[i] ? {fill, stage[i][W-1:D]} : stage[i];
        end
    endgenerate

    assign y = ctl.left ? out_rev : stage[SW];
endmodule

// File: rtl/bitu_lead.sv
module bitu_lead #(
    parameter int W  = bitu_pkg::DATA_W,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  a,
    input  logic          count_ones,
    output logic [CW-1:0] cnt
);
    logic [W-1:0] x;

    assign x = count_ones ? ~a : a;

    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (x[i])
                cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/bitu_bytes.sv
module bitu_bytes #(
    parameter int W = bitu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         sext,
    output logic [W-1:0] y
);
    localparam int HALVES = W / 16;

    logic [W-1:0] swapped;
    logic [W-1:0] extended;

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            assign swapped[16*h +: 8]     = a[16*h + 8 +: 8];
            assign swapped[16*h + 8 +: 8] = a[16*h +: 8];
        end
    endgenerate

    assign extended = {{(W-8){a[7]}}, a[7:0]};
    assign y = sext ? extended : swapped;
endmodule

// File: rtl/bitu_top.sv
module bitu_top #(
    parameter int W    = bitu_pkg::DATA_W,
    parameter int SW   = $clog2(W),
    parameter int OPW  = bitu_pkg::OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic [SW-1:0]  shamt_i,
    output logic [W-1:0]   res_o
);
    import bitu_pkg::*;

    localparam int CW = SW + 1;

    dec_t          dec;
    logic [W-1:0]  logic_y;
    logic [W-1:0]  shift_y;
    logic [CW-1:0] lead_cnt;
    logic [W-1:0]  bytes_y;
    logic [W-1:0]  res_d;

    assign dec = decode_op(op_i);

    bitu_logic #(.W(W)) u_logic (
        .a  (opa_i),
        .b  (opb_i),
        .fn (dec.logic_fn),
        .y  (logic_y)
    );

    bitu_shift #(.W(W), .SW(SW)) u_shift (
        .a   (opa_i),
        .amt (shamt_i),
        .ctl (dec.sh),
        .y   (shift_y)
    );

    bitu_lead #(.W(W), .CW(CW)) u_lead (
        .a          (opa_i),
        .count_ones (dec.count_ones),
        .cnt        (lead_cnt)
    );

    bitu_bytes #(.W(W)) u_bytes (
        .a    (opa_i),
        .sext (dec.byte_sext),
        .y    (bytes_y)
    );

    always_comb begin
        res_d = '0;
        if (dec.valid_code) begin
            case (dec.src)
                SRC_LOGIC: res_d = logic_y;
                SRC_SHIFT: res_d = shift_y;
                SRC_COUNT: res_d = W'(lead_cnt);
                default:   res_d = bytes_y;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_o <= '0;
        else
            res_o <= res_d;
    end
endmodule

// File: rtl/bitu_checker.sv
module bitu_checker #(
    parameter int W   = bitu_pkg::DATA_W,
    parameter int SW  = $clog2(W),
    parameter int OPW = bitu_pkg::OP_W
) (
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] op_i,
    input logic [W-1:0]   opa_i,
    input logic [W-1:0]   opb_i,
    input logic [SW-1:0]  shamt_i,
    input logic [W-1:0]   res_o
);
    logic seen;
    always_ff @(posedge clk) seen <= 1'b1;

    p_reset_clear_r1: assert property (@(posedge clk)
        (seen && $past(rst)) |-> (res_o == '0));

    p_and_fn_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd0) |=> (res_o == ($past(opa_i) & $past(opb_i))));

    p_zero_amount_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i[3:2] == 2'b01 && shamt_i == '0) |=> (res_o == $past(opa_i)));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8 || op_i == 4'd9) |=> (res_o <= W));

    p_halfword_swap_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd10) |=> (res_o[15:0] == {$past(opa_i[7:0]), $past(opa_i[15:8])}));

    p_byte_sext_r11: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd11) |=> (res_o == {{(W-8){$past(opa_i[7])}}, $past(opa_i[7:0])}));

    p_unused_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (op_i[3:2] == 2'b11) |=> (res_o == '0));
endmodule

bind bitu_top bitu_checker #(.W(W), .SW(SW), .OPW(OPW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .shamt_i (shamt_i),
    .res_o   (res_o)
);

// File: tb/bitu_top_tb_top.sv
module bitu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] res_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bitu_top dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i),
        .opb_i(opb_i), .shamt_i(shamt_i), .res_o(res_o)
    );

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input int s);
        logic [31:0] r;
        int n;
        r = '0;
        case (op)
            4'd0: for (int i = 0; i < 32; i++) r[i] = a[i] && b[i];
            4'd1: for (int i = 0; i < 32; i++) r[i] = a[i] || b[i];
            4'd2: for (int i = 0; i < 32; i++) r[i] = a[i] != b[i];
            4'd3: for (int i = 0; i < 32; i++) r[i] = !(a[i] || b[i]);
            4'd4: for (int i = 0; i < 32; i++) r[i] = (i >= s) ? a[i-s] : 1'b0;
            4'd5: for (int i = 0; i < 32; i++) r[i] = (i + s < 32) ? a[i+s] : 1'b0;
            4'd6: for (int i = 0; i < 32; i++) r[i] = (i + s < 32) ? a[i+s] : a[31];
            4'd7: for (int i = 0; i < 32; i++) r[i] = a[(i + s) % 32];
            4'd8, 4'd9: begin
                n = 0;
                for (int i = 31; i >= 0; i--) begin
                    if (a[i] == (op == 4'd8) && n == 31 - i) n++;
                end
                r = n;
            end
            4'd10: for (int i = 0; i < 32; i++) r[i] = a[(i / 16) * 16 + ((i % 16) + 8) % 16];
            4'd11: for (int i = 0; i < 32; i++) r[i] = (i < 8) ? a[i] : a[7];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (res_o !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, res_o, exp);
        end
    endtask

    // drive at a falling edge, result is registered at the next rising edge
    task automatic apply(input string req, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] s);
        op_i = op; opa_i = a; opb_i = b; shamt_i = s;
        @(negedge clk);
        check(req, model(op, a, b, int'(s)));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        op_i = 4'd1; opa_i = 32'hFFFF_FFFF; opb_i = 32'h1;
        @(negedge clk);
        check("R1", 32'h0);
        @(negedge clk);
        check("R1", 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_logic;
        apply("R3", 4'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd9);
        apply("R3", 4'd1, 32'hA000_0005, 32'h0500_00A0, 5'd3);
        apply("R3", 4'd2, 32'hDEAD_BEEF, 32'hFFFF_0000, 5'd0);
        apply("R3", 4'd3, 32'h1234_5678, 32'h8000_0001, 5'd31);
    endtask

    task automatic t_shifts;
        apply("R4", 4'd4, 32'h8000_0001, 32'h0, 5'd1);
        apply("R4", 4'd4, 32'hFFFF_FFFF, 32'h0, 5'd31);
        apply("R4", 4'd5, 32'hF000_000F, 32'h0, 5'd4);
        apply("R4", 4'd5, 32'h8000_0000, 32'h0, 5'd31);
        apply("R5", 4'd6, 32'h8000_0000, 32'h0, 5'd31);
        apply("R5", 4'd6, 32'h9234_5678, 32'h0, 5'd12);
        apply("R5", 4'd6, 32'h7FFF_FFFF, 32'h0, 5'd17);
    endtask

    task automatic t_rotate;
        apply("R6", 4'd7, 32'h0000_0001, 32'h0, 5'd1);
        apply("R6", 4'd7, 32'h1234_5678, 32'h0, 5'd8);
        apply("R6", 4'd7, 32'h8000_0003, 32'h0, 5'd31);
    endtask

    task automatic t_zero_amount;
        for (int k = 4; k < 8; k++)
            apply("R7", 4'(k), 32'hC3A5_5A3C, 32'h0, 5'd0);
    endtask

    task automatic t_counts;
        apply("R8", 4'd8, 32'hF0FF_FFFF, 32'h0, 5'd0);
        apply("R8", 4'd8, 32'h7FFF_FFFF, 32'h0, 5'd0);
        apply("R8", 4'd9, 32'h0001_0000, 32'h0, 5'd0);
        apply("R8", 4'd9, 32'h0000_0001, 32'h0, 5'd0);
        apply("R8", 4'd9, 32'h8000_0000, 32'h0, 5'd0);
        apply("R9", 4'd8, 32'hFFFF_FFFF, 32'h0, 5'd0);
        apply("R9", 4'd9, 32'h0000_0000, 32'h0, 5'd0);
    endtask

    task automatic t_bytes;
        apply("R10", 4'd10, 32'h1122_3344, 32'h0, 5'd0);
        apply("R10", 4'd10, 32'hFF00_00FF, 32'h0, 5'd0);
        apply("R11", 4'd11, 32'h1234_5680, 32'h0, 5'd0);
        apply("R11", 4'd11, 32'hFFFF_FF7F, 32'h0, 5'd0);
    endtask

    task automatic t_unused;
        for (int k = 12; k < 16; k++)
            apply("R12", 4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd7);
    endtask

    task automatic t_ignored;
        // secondary operand varies under shift, count and byte codes
        apply("R13", 4'd7, 32'h89AB_CDEF, 32'hFFFF_FFFF, 5'd5);
        apply("R13", 4'd7, 32'h89AB_CDEF, 32'h0000_0000, 5'd5);
        apply("R13", 4'd9, 32'h0000_F000, 32'h1234_5678, 5'd0);
        apply("R13", 4'd10, 32'hCAFE_BABE, 32'h5555_AAAA, 5'd0);
        // shift amount varies under logic, count and byte codes
        apply("R13", 4'd2, 32'h0F0F_0F0F, 32'h3333_3333, 5'd31);
        apply("R13", 4'd8, 32'hE000_0000, 32'h0, 5'd19);
        apply("R13", 4'd11, 32'h0000_0081, 32'h0, 5'd11);
    endtask

    task automatic t_back_to_back;
        // R2: a different operation every cycle, each judged one edge later
        apply("R2", 4'd7, 32'hA5A5_0001, 32'h0, 5'd16);
        apply("R2", 4'd9, 32'h0000_0100, 32'h0, 5'd16);
        apply("R2", 4'd10, 32'hA5A5_0001, 32'h0, 5'd16);
        apply("R2", 4'd6, 32'hF000_0000, 32'h0, 5'd3);
        apply("R2", 4'd3, 32'h0000_0000, 32'h0, 5'd3);
        apply("R2", 4'd4, 32'h0000_0003, 32'h0, 5'd30);
        apply("R2", 4'd14, 32'h1, 32'h1, 5'd1);
        apply("R2", 4'd8, 32'hFFFF_0000, 32'h0, 5'd1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_logic();
        t_shifts();
        t_rotate();
        t_zero_amount();
        t_counts();
        t_bytes();
        t_unused();
        t_ignored();
        t_back_to_back();
        // R1 again: reset in mid-stream clears the register
        op_i = 4'd1; opa_i = 32'h5; opb_i = 32'h0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 32'h0);
        rst = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule